// File: doc/BRIEF.md
# SD Host Multi-Slot Global Register Front End

This block is the shared register front end placed ahead of one or two SD host controller slots. It decodes a 4 KiB register window. The lowest 256 bytes hold the global words: an information word, a debounce word, write-protect polarity, card detect, interrupt status and general storage. The same area holds per-slot shadow copies of each slot's 64-bit capability value and 32-bit maximum-current value. The slots read these shadows through dedicated output ports. Each slot also has a 256-byte sub-window above the global area, and accesses there are forwarded to that slot's own register port.

The block collects the slot interrupt lines into the interrupt status word and drives one combined interrupt output. A write that sets the low bit of the information word raises a one-cycle reset request and leaves no trace in the stored value. The bus is a simple valid/write/address/data interface with byte strobes. Every read returns its data exactly one cycle after the request.

Top module: `sdh_glue_regs`

## Requirements
- R1: After reset the information word (0x00) reads 0x00010000 with 0x00020000 also set when NUM_SLOTS is 2, the debounce word (0x04) reads DEBOUNCE_RESET (default 5), each slot capability shadow holds CAP_RESET, each maximum-current shadow holds MAXCUR_RESET and every other global word reads 0.
- R2: A write to the information word stores every strobed bit except bit 0, which always reads 0; when byte lane 0 is strobed with bit 0 set, soft_rst_req is high for exactly the following cycle, otherwise it stays low.
- R3: For each present slot s, offset 0x10+0x10*s reads and writes bits 31:0 and offset 0x14+0x10*s reads and writes bits 63:32 of that slot's capability shadow; a write to one half leaves the other unchanged, and slot_cap[64*s +: 64] shows the shadow.
- R4: For each present slot s, offset 0x18+0x10*s reads and writes that slot's maximum-current shadow, shown on slot_maxcur[32*s +: 32].
- R5: Any other offset below 0x100 is a 32-bit storage word picked by addr[7:2]; byte strobe bit k writes wdata[8k+7:8k] and unstrobed lanes keep their value; with NUM_SLOTS=1 the slot-1 shadow offsets 0x20 to 0x28 are plain storage.
- R6: Interrupt status (0xFC): bit s is set in the cycle after slot_irq[s] rises and cleared in the cycle after it falls; software writes store strobed bits, but a slot line event in the same cycle wins for its bit.
- R7: irq_out is high exactly when any status bit belonging to a present slot is set.
- R8: An access with address in [(s+1)*0x100, (s+1)*0x100+0xFF] for a present slot s asserts slot_sel[s] in the same cycle with slot_addr = addr[7:0] and the write flag, data and strobes passed through; it changes no global state, and a read returns slot_rdata[32*s +: 32] one cycle later.
- R9: An address at or above (NUM_SLOTS+1)*0x100 reads 0, selects no slot and changes no state.
- R10: bus_rvalid is high in the cycle after each read request and low otherwise; back-to-back reads are allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address in the window |
| bus_wdata | input | 32 | Write data |
| bus_strb | input | 4 | Byte strobes for writes |
| bus_rvalid | output | 1 | Read data valid, one cycle after request |
| bus_rdata | output | 32 | Read data |
| soft_rst_req | output | 1 | One-cycle reset request pulse |
| slot_sel | output | NUM_SLOTS | Per-slot access select |
| slot_write | output | 1 | Forwarded write flag |
| slot_addr | output | 8 | Offset inside the slot sub-window |
| slot_wdata | output | 32 | Forwarded write data |
| slot_strb | output | 4 | Forwarded byte strobes |
| slot_rdata | input | 32*NUM_SLOTS | Slot read data, one cycle after select |
| slot_irq | input | NUM_SLOTS | Slot interrupt levels |
| slot_cap | output | 64*NUM_SLOTS | Capability shadows |
| slot_maxcur | output | 32*NUM_SLOTS | Maximum-current shadows |
| irq_out | output | 1 | Combined interrupt |

## Verification
The bench builds two copies side by side on the same bus. One has NUM_SLOTS=2 and capability reset 0x0000000719F80080. The other has NUM_SLOTS=1 and capability reset 0x0000000001E80080. The two-slot copy exercises both sub-windows, both shadow sets, and an interrupt on one slot that is isolated from the other. The one-slot copy shows the information word without the second presence bit, the slot-1 window read as out of range, and the slot-1 shadow offsets acting as plain storage.

// File: rtl/sdh_glue_pkg.sv
package sdh_glue_pkg;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_GLOBAL,
    TGT_INFO,
    TGT_IRQ,
    TGT_CAPLO,
    TGT_CAPHI,
    TGT_MAXCUR,
    TGT_SLOT
  } tgt_e;

  typedef struct packed {
    tgt_e       tgt;
    logic [5:0] word;
    logic [3:0] slot;
  } dec_t;

  // byte-lane merge of a partial write into a stored word
  function automatic logic [31:0] merge_bytes(input logic [31:0] old_v,
                                              input logic [31:0] new_v,
                                              input logic [3:0]  strb);
    logic [31:0] r;
    for (int k = 0; k < 4; k++)
      r[8*k +: 8] = strb[k] ? new_v[8*k +: 8] : old_v[8*k +: 8];
    return r;
  endfunction

  // information word: bit 0 is a request only and never stored
  function automatic logic [31:0] info_write(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [3:0]  strb);
    return merge_bytes(old_v, new_v, strb) & ~32'h1;
  endfunction

  function automatic logic [31:0] info_reset(input int nslots);
    return 32'h0001_0000 | ((nslots == 2) ? 32'h0002_0000 : 32'h0);
  endfunction

endpackage

// File: rtl/sdh_addr_decode.sv
module sdh_addr_decode
  import sdh_glue_pkg::*;
#(
  parameter int NUM_SLOTS = 2,
  parameter int ADDR_W    = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  localparam int WIN_W = ADDR_W - 8;

  logic [WIN_W-1:0] win;
  assign win = addr[ADDR_W-1:8];

  always_comb begin
    dec.tgt  = TGT_NONE;
    dec.word = addr[7:2];
    dec.slot = '0;
    if (win == '0) begin
      if (addr[7:2] == 6'h00)      dec.tgt = TGT_INFO;
      else if (addr[7:2] == 6'h3F) dec.tgt = TGT_IRQ;
      else                         dec.tgt = TGT_GLOBAL;
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (int'(addr[7:4]) == s + 1) begin
          dec.slot = 4'(s);
          case (addr[3:2])
            2'd0:    dec.tgt = TGT_CAPLO;
            2'd1:    dec.tgt = TGT_CAPHI;
            2'd2:    dec.tgt = TGT_MAXCUR;
            default: ;
          endcase
        end
      end
    end else if (int'(win) <= NUM_SLOTS) begin
      dec.tgt  = TGT_SLOT;
      dec.slot = 4'(int'(win) - 1);
    end
  end
endmodule

// File: rtl/sdh_slot_shadow.sv
module sdh_slot_shadow
  import sdh_glue_pkg::*;
#(
  parameter logic [63:0] CAP_RESET    = 64'h0000_0007_19F8_0080,
  parameter logic [31:0] MAXCUR_RESET = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic        wr_mc,
  input  logic [31:0] wdata,
  input  logic [3:0]  strb,
  output logic [63:0] cap,
  output logic [31:0] maxcur
);
  logic [63:0] cap_q;
  logic [31:0] mc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= CAP_RESET;
      mc_q  <= MAXCUR_RESET;
    end else begin
      if (wr_lo) cap_q[31:0]  <= merge_bytes(cap_q[31:0], wdata, strb);
      if (wr_hi) cap_q[63:32] <= merge_bytes(cap_q[63:32], wdata, strb);
      if (wr_mc) mc_q         <= merge_bytes(mc_q, wdata, strb);
    end
  end

  assign cap    = cap_q;
  assign maxcur = mc_q;

  // R3
  cap_hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi) |=> $stable(cap_q[63:32]));
  // R3
  cap_lo_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo) |=> $stable(cap_q[31:0]));
endmodule

// File: rtl/sdh_irq_gather.sv
module sdh_irq_gather
  import sdh_glue_pkg::*;
#(
  parameter int NUM_SLOTS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] slot_irq,
  input  logic                 sw_we,
  input  logic [31:0]          sw_wdata,
  input  logic [3:0]           sw_strb,
  output logic [31:0]          stat,
  output logic                 irq_out
);
  logic [31:0]          stat_q, stat_d;
  logic [NUM_SLOTS-1:0] prev_q;
  logic [NUM_SLOTS-1:0] rise_ev, fall_ev;

  assign rise_ev = slot_irq & ~prev_q;
  assign fall_ev = ~slot_irq & prev_q;

  always_comb begin
    stat_d = sw_we ? merge_bytes(stat_q, sw_wdata, sw_strb) : stat_q;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (rise_ev[s]) stat_d[s] = 1'b1;
      if (fall_ev[s]) stat_d[s] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      prev_q <= '0;
    end else begin
      stat_q <= stat_d;
      prev_q <= slot_irq;
    end
  end

  assign stat    = stat_q;
  assign irq_out = |stat_q[NUM_SLOTS-1:0];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_chk
    // R6
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_ev[s] |=> stat_q[s]);
    // R6
    irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall_ev[s] |=> !stat_q[s]);
    // R7
    irq_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_ev[s] |=> irq_out);
  end
endmodule

// File: rtl/sdh_glue_regs.sv
module sdh_glue_regs
  import sdh_glue_pkg::*;
#(
  parameter int          NUM_SLOTS      = 2,
  parameter int          ADDR_W         = 12,
  parameter logic [63:0] CAP_RESET      = 64'h0000_0007_19F8_0080,
  parameter logic [31:0] MAXCUR_RESET   = 32'h0,
  parameter logic [31:0] DEBOUNCE_RESET = 32'h0000_0005
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_valid,
  input  logic                    bus_write,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [31:0]             bus_wdata,
  input  logic [3:0]              bus_strb,
  output logic                    bus_rvalid,
  output logic [31:0]             bus_rdata,
  output logic                    soft_rst_req,
  output logic [NUM_SLOTS-1:0]    slot_sel,
  output logic                    slot_write,
  output logic [7:0]              slot_addr,
  output logic [31:0]             slot_wdata,
  output logic [3:0]              slot_strb,
  input  logic [32*NUM_SLOTS-1:0] slot_rdata,
  input  logic [NUM_SLOTS-1:0]    slot_irq,
  output logic [64*NUM_SLOTS-1:0] slot_cap,
  output logic [32*NUM_SLOTS-1:0] slot_maxcur,
  output logic                    irq_out
);
  localparam int GWORDS = 64;

  dec_t        dec;
  logic        wr_acc, rd_acc;
  logic        glob_we, info_we, irq_we;
  logic [NUM_SLOTS-1:0] shadow_we;
  logic [31:0] g_q [GWORDS];
  logic [31:0] irq_stat;
  logic [31:0] rd_val, rdata_q;
  logic        rvalid_q, rslot_q, soft_rst_q;
  logic [3:0]  rslot_idx_q;

  sdh_addr_decode #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .dec(dec)
  );

  assign wr_acc  = bus_valid && bus_write;
  assign rd_acc  = bus_valid && !bus_write;
  assign glob_we = wr_acc && (dec.tgt == TGT_GLOBAL);
  assign info_we = wr_acc && (dec.tgt == TGT_INFO);
  assign irq_we  = wr_acc && (dec.tgt == TGT_IRQ);

  // per-slot shadows and forwarding
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic hit;
    logic wlo, whi, wmc;
    assign hit = (dec.slot == 4'(s));
    assign wlo = wr_acc && hit && (dec.tgt == TGT_CAPLO);
    assign whi = wr_acc && hit && (dec.tgt == TGT_CAPHI);
    assign wmc = wr_acc && hit && (dec.tgt == TGT_MAXCUR);
    assign shadow_we[s] = wlo || whi || wmc;
    assign slot_sel[s]  = bus_valid && hit && (dec.tgt == TGT_SLOT);

    sdh_slot_shadow #(.CAP_RESET(CAP_RESET), .MAXCUR_RESET(MAXCUR_RESET)) u_shadow (
      .clk(clk), .rst_n(rst_n),
      .wr_lo(wlo), .wr_hi(whi), .wr_mc(wmc),
      .wdata(bus_wdata), .strb(bus_strb),
      .cap(slot_cap[64*s +: 64]),
      .maxcur(slot_maxcur[32*s +: 32])
    );
  end

  assign slot_write = bus_write;
  assign slot_addr  = bus_addr[7:0];
  assign slot_wdata = bus_wdata;
  assign slot_strb  = bus_strb;

  sdh_irq_gather #(.NUM_SLOTS(NUM_SLOTS)) u_irq (
    .clk(clk), .rst_n(rst_n), .slot_irq(slot_irq),
    .sw_we(irq_we), .sw_wdata(bus_wdata), .sw_strb(bus_strb),
    .stat(irq_stat), .irq_out(irq_out)
  );

  // global storage words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < GWORDS; i++) g_q[i] <= '0;
      g_q[0] <= info_reset(NUM_SLOTS);
      g_q[1] <= DEBOUNCE_RESET;
      soft_rst_q <= 1'b0;
    end else begin
      if (glob_we) g_q[dec.word] <= merge_bytes(g_q[dec.word], bus_wdata, bus_strb);
      if (info_we) g_q[0] <= info_write(g_q[0], bus_wdata, bus_strb);
      soft_rst_q <= info_we && bus_strb[0] && bus_wdata[0];
    end
  end

  assign soft_rst_req = soft_rst_q;

  // read selection
  always_comb begin
    rd_val = '0;
    case (dec.tgt)
      TGT_GLOBAL, TGT_INFO: rd_val = g_q[dec.word];
      TGT_IRQ:    rd_val = irq_stat;
      TGT_CAPLO:  rd_val = slot_cap[64*int'(dec.slot) +: 32];
      TGT_CAPHI:  rd_val = slot_cap[64*int'(dec.slot) + 32 +: 32];
      TGT_MAXCUR: rd_val = slot_maxcur[32*int'(dec.slot) +: 32];
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q    <= 1'b0;
      rdata_q     <= '0;
      rslot_q     <= 1'b0;
      rslot_idx_q <= '0;
    end else begin
      rvalid_q    <= rd_acc;
      rdata_q     <= rd_acc ? rd_val : '0;
      rslot_q     <= rd_acc && (dec.tgt == TGT_SLOT);
      rslot_idx_q <= dec.slot;
    end
  end

  assign bus_rvalid = rvalid_q;
  assign bus_rdata  = rslot_q ? slot_rdata[32*int'(rslot_idx_q) +: 32] : rdata_q;

  // R10
  rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> bus_rvalid);
  // R10
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> !bus_rvalid);
  // R8
  slot_sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_sel));
  // R8
  slot_no_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|slot_sel) |-> (!glob_we && !info_we && !irq_we && (shadow_we == '0)));
  // R9
  range_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && dec.tgt == TGT_NONE) |-> (slot_sel == '0 && !glob_we && !info_we
                                            && !irq_we && shadow_we == '0));
  // R9
  range_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && dec.tgt == TGT_NONE) |=> (bus_rdata == '0));
endmodule

// File: tb/test_sdh_glue_regs.sv
module slot_stub #(parameter int NS = 2) (
  input  logic           clk,
  input  logic [NS-1:0]  sel,
  input  logic           wr,
  input  logic [7:0]     ad,
  output logic [NS*32-1:0] rdata
);
  logic [7:0] last [NS];
  initial for (int i = 0; i < NS; i++) last[i] = 8'h00;
  always @(posedge clk)
    for (int i = 0; i < NS; i++) if (sel[i] && !wr) last[i] <= ad;
  for (genvar i = 0; i < NS; i++) begin : g_r
    assign rdata[32*i +: 32] = {16'h5100 + 16'(i), 8'h00, last[i]};
  end
endmodule

module ref_model #(parameter int NS = 2, parameter logic [63:0] CAP = 64'h0) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          v,
  input  logic          w,
  input  logic [11:0]   a,
  input  logic [31:0]   d,
  input  logic [3:0]    s,
  input  logic [NS-1:0] irq,
  output logic          rv,
  output logic [31:0]   rd,
  output logic          rst_o,
  output logic          irq_o,
  output logic [NS*64-1:0] cap_o,
  output logic [NS*32-1:0] mc_o
);
  logic [31:0] g [64];
  logic [63:0] capm [2];
  logic [31:0] mcm [2];
  logic [1:0]  prev;
  string tag;

  function automatic logic [31:0] mrg(logic [31:0] o, logic [31:0] n, logic [3:0] st);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[8*k +: 8] = st[k] ? n[8*k +: 8] : o[8*k +: 8];
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) g[i] = 0;
      g[0] = (NS == 2) ? 32'h0003_0000 : 32'h0001_0000;
      g[1] = 5;
      for (int i = 0; i < 2; i++) begin capm[i] = CAP; mcm[i] = 0; end
      prev = 0; rv = 0; rd = 0; rst_o = 0; tag = "R1";
    end else begin
      int win, wd, sl, part;
      bit sh;
      win = int'(a[11:8]); wd = int'(a[7:2]);
      sl = int'(a[7:4]) - 1; part = int'(a[3:2]);
      sh = (a[7:4] >= 1) && (int'(a[7:4]) <= NS) && (part < 3);
      rv = v && !w; rd = 0; rst_o = 0;
      if (v) begin
        if (win == 0) begin
          tag = sh ? "R3" : (wd == 63 ? "R6" : (wd == 0 ? "R2" : "R5"));
          if (!w) begin
            if (sh) rd = (part == 0) ? capm[sl][31:0] : (part == 1) ? capm[sl][63:32] : mcm[sl];
            else    rd = g[wd];
          end else if (sh) begin
            if (part == 0) capm[sl][31:0] = mrg(capm[sl][31:0], d, s);
            else if (part == 1) capm[sl][63:32] = mrg(capm[sl][63:32], d, s);
            else mcm[sl] = mrg(mcm[sl], d, s);
          end else if (wd == 0) begin
            g[0] = mrg(g[0], d, s) & ~32'h1;
            rst_o = s[0] && d[0];
          end else g[wd] = mrg(g[wd], d, s);
        end else if (win <= NS) begin
          tag = "R8";
          if (!w) rd = {16'h5100 + 16'(win - 1), 8'h00, a[7:0]};
        end else tag = "R9";
      end
      for (int i = 0; i < NS; i++) begin
        if (irq[i] && !prev[i]) g[63][i] = 1'b1;
        if (!irq[i] && prev[i]) g[63][i] = 1'b0;
        prev[i] = irq[i];
      end
    end
    irq_o = |g[63][NS-1:0];
    for (int i = 0; i < NS; i++) begin
      cap_o[64*i +: 64] = capm[i];
      mc_o[32*i +: 32]  = mcm[i];
    end
  end
endmodule

module test_sdh_glue_regs;
  logic clk = 0;
  always #10 clk = ~clk;

  logic rst_n = 0, v = 0, w = 0;
  logic [11:0] a = 0;
  logic [31:0] d = 0;
  logic [3:0]  s = 0;
  logic [1:0]  irq_in = 0;

  logic rv_a, srst_a, sw_a, irq_a;
  logic [31:0] rd_a, swd_a;
  logic [1:0] sel_a; logic [7:0] sa_a; logic [3:0] sst_a;
  logic [63:0] srd_a, mc_a; logic [127:0] cap_a;
  logic rv_b, srst_b, sw_b, irq_b;
  logic [31:0] rd_b, swd_b, srd_b, mc_b;
  logic [0:0] sel_b; logic [7:0] sa_b; logic [3:0] sst_b;
  logic [63:0] cap_b;

  sdh_glue_regs #(.NUM_SLOTS(2), .CAP_RESET(64'h0000_0007_19F8_0080)) i_sdh_glue_regs (
    .clk(clk), .rst_n(rst_n), .bus_valid(v), .bus_write(w), .bus_addr(a),
    .bus_wdata(d), .bus_strb(s), .bus_rvalid(rv_a), .bus_rdata(rd_a),
    .soft_rst_req(srst_a), .slot_sel(sel_a), .slot_write(sw_a), .slot_addr(sa_a),
    .slot_wdata(swd_a), .slot_strb(sst_a), .slot_rdata(srd_a), .slot_irq(irq_in),
    .slot_cap(cap_a), .slot_maxcur(mc_a), .irq_out(irq_a));

  sdh_glue_regs #(.NUM_SLOTS(1), .CAP_RESET(64'h0000_0000_01E8_0080)) i_sdh_glue_regs_one (
    .clk(clk), .rst_n(rst_n), .bus_valid(v), .bus_write(w), .bus_addr(a),
    .bus_wdata(d), .bus_strb(s), .bus_rvalid(rv_b), .bus_rdata(rd_b),
    .soft_rst_req(srst_b), .slot_sel(sel_b), .slot_write(sw_b), .slot_addr(sa_b),
    .slot_wdata(swd_b), .slot_strb(sst_b), .slot_rdata(srd_b), .slot_irq(irq_in[0:0]),
    .slot_cap(cap_b), .slot_maxcur(mc_b), .irq_out(irq_b));

  slot_stub #(.NS(2)) stub_a (.clk(clk), .sel(sel_a), .wr(sw_a), .ad(sa_a), .rdata(srd_a));
  slot_stub #(.NS(1)) stub_b (.clk(clk), .sel(sel_b), .wr(sw_b), .ad(sa_b), .rdata(srd_b));

  logic m_rv_a, m_rst_a, m_irq_a, m_rv_b, m_rst_b, m_irq_b;
  logic [31:0] m_rd_a, m_rd_b, m_mc_b;
  logic [127:0] m_cap_a; logic [63:0] m_cap_b, m_mc_a;

  ref_model #(.NS(2), .CAP(64'h0000_0007_19F8_0080)) ma (
    .clk(clk), .rst_n(rst_n), .v(v), .w(w), .a(a), .d(d), .s(s), .irq(irq_in),
    .rv(m_rv_a), .rd(m_rd_a), .rst_o(m_rst_a), .irq_o(m_irq_a), .cap_o(m_cap_a), .mc_o(m_mc_a));
  ref_model #(.NS(1), .CAP(64'h0000_0000_01E8_0080)) mb (
    .clk(clk), .rst_n(rst_n), .v(v), .w(w), .a(a), .d(d), .s(s), .irq(irq_in[0:0]),
    .rv(m_rv_b), .rd(m_rd_b), .rst_o(m_rst_b), .irq_o(m_irq_b), .cap_o(m_cap_b), .mc_o(m_mc_b));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the reference model
  always @(negedge clk) if (!done) begin
    chk("R10 rvalid two-slot", 64'(rv_a), 64'(m_rv_a));
    chk("R10 rvalid one-slot", 64'(rv_b), 64'(m_rv_b));
    if (m_rv_a) chk({ma.tag, " read two-slot"}, 64'(rd_a), 64'(m_rd_a));
    if (m_rv_b) chk({mb.tag, " read one-slot"}, 64'(rd_b), 64'(m_rd_b));
    chk("R2 soft reset two-slot", 64'(srst_a), 64'(m_rst_a));
    chk("R2 soft reset one-slot", 64'(srst_b), 64'(m_rst_b));
    chk("R7 irq two-slot", 64'(irq_a), 64'(m_irq_a));
    chk("R7 irq one-slot", 64'(irq_b), 64'(m_irq_b));
    chk("R3 cap slot0 two-slot", cap_a[63:0], m_cap_a[63:0]);
    chk("R3 cap slot1 two-slot", cap_a[127:64], m_cap_a[127:64]);
    chk("R3 cap one-slot", cap_b, m_cap_b);
    chk("R4 maxcur two-slot", mc_a, m_mc_a);
    chk("R4 maxcur one-slot", 64'(mc_b), 64'(m_mc_b));
  end

  task automatic op(input logic wr, input logic [11:0] ad, input logic [31:0] dat,
                    input logic [3:0] st);
    logic [1:0] es;
    @(negedge clk);
    v = 1; w = wr; a = ad; d = dat; s = st;
    #1;
    es = (ad[11:8] == 4'd1) ? 2'b01 : (ad[11:8] == 4'd2) ? 2'b10 : 2'b00;
    chk("R8 slot select two-slot", 64'(sel_a), 64'(es));
    chk("R8 slot select one-slot", 64'(sel_b), 64'(es[0]));
    if (es != 0) chk("R8 slot offset", 64'(sa_a), 64'(ad[7:0]));
    @(posedge clk);
    #1 v = 0; w = 0;
  endtask

  task automatic rdc(input logic [11:0] ad, input logic [31:0] ea, input logic [31:0] eb,
                     input string tag);
    op(0, ad, 0, 0);
    @(negedge clk);
    chk({tag, " two-slot"}, 64'(rd_a), 64'(ea));
    chk({tag, " one-slot"}, 64'(rd_b), 64'(eb));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    rdc(12'h000, 32'h0003_0000, 32'h0001_0000, "R1 info");
    rdc(12'h004, 32'h5, 32'h5, "R1 debounce");
    rdc(12'h0EC, 0, 0, "R1 wp polarity");
    rdc(12'h0F0, 0, 0, "R1 card detect");
    rdc(12'h010, 32'h19F8_0080, 32'h01E8_0080, "R1 cap low");
    rdc(12'h014, 32'h7, 32'h0, "R1 cap high");
    rdc(12'h020, 32'h19F8_0080, 32'h0, "R1 slot1 cap low");
    rdc(12'h018, 0, 0, "R1 maxcur");
    // R2 self-clearing bit 0
    op(1, 12'h000, 32'hFFFF_FFFF, 4'hF);
    @(negedge clk); chk("R2 pulse", 64'(srst_a), 1);
    rdc(12'h000, 32'hFFFF_FFFE, 32'hFFFF_FFFE, "R2 bit0 reads 0");
    op(1, 12'h000, 32'h0000_0001, 4'b1110);
    @(negedge clk); chk("R2 no pulse unstrobed", 64'(srst_a), 0);
    rdc(12'h000, 32'h0000_00FE, 32'h0000_00FE, "R2 lanes");
    // R3 split capability
    op(1, 12'h010, 32'h1234_5678, 4'hF);
    rdc(12'h014, 32'h7, 32'h0, "R3 high kept");
    rdc(12'h010, 32'h1234_5678, 32'h1234_5678, "R3 low written");
    op(1, 12'h024, 32'hAABB_CCDD, 4'b0010);
    rdc(12'h024, 32'h0000_CC07, 32'h0000_CC00, "R3 high strobe");
    rdc(12'h020, 32'h19F8_0080, 32'h0, "R3 low kept");
    op(1, 12'h014, 32'h0000_0042, 4'hF);
    rdc(12'h010, 32'h1234_5678, 32'h1234_5678, "R3 low kept after high");
    // R4 max current
    op(1, 12'h018, 32'h640, 4'hF);
    op(1, 12'h028, 32'h320, 4'hF);
    rdc(12'h018, 32'h640, 32'h640, "R4 slot0");
    rdc(12'h028, 32'h320, 32'h320, "R4 slot1");
    chk("R4 port two-slot", mc_a, {32'h320, 32'h640});
    // R5 plain storage and strobes
    op(1, 12'h0EC, 32'h1111_2222, 4'b0101);
    rdc(12'h0EC, 32'h0011_0022, 32'h0011_0022, "R5 strobe merge");
    op(1, 12'h080, 32'hDEAD_BEEF, 4'hF);
    op(1, 12'h080, 32'h0, 4'b1000);
    rdc(12'h080, 32'h00AD_BEEF, 32'h00AD_BEEF, "R5 upper lane");
    // R8 slot windows
    op(1, 12'h104, 32'hCAFE_0001, 4'hF);
    rdc(12'h1A8, 32'h5100_00A8, 32'h5100_00A8, "R8 slot0 read");
    rdc(12'h2FC, 32'h5101_00FC, 32'h0, "R8 slot1 read");
    op(1, 12'h230, 32'h1, 4'hF);
    rdc(12'h004, 32'h5, 32'h5, "R8 global untouched");
    // R9 out of range
    op(1, 12'h300, 32'hFFFF_FFFF, 4'hF);
    op(1, 12'hFFC, 32'hFFFF_FFFF, 4'hF);
    rdc(12'h300, 0, 0, "R9 read zero");
    rdc(12'h000, 32'h0000_00FE, 32'h0000_00FE, "R9 no alias info");
    rdc(12'h0FC, 0, 0, "R9 no alias status");
    // R6 and R7 interrupts
    @(negedge clk); irq_in = 2'b10;
    @(negedge clk); @(negedge clk);
    chk("R7 slot1 raises two-slot", 64'(irq_a), 1);
    chk("R7 isolated one-slot", 64'(irq_b), 0);
    rdc(12'h0FC, 32'h2, 32'h0, "R6 set");
    @(negedge clk); irq_in = 2'b01;
    @(negedge clk); @(negedge clk);
    rdc(12'h0FC, 32'h1, 32'h1, "R6 set and clear");
    op(1, 12'h0FC, 32'hA5A5_0000, 4'hF);
    @(negedge clk);
    chk("R7 cleared by write", 64'(irq_a), 0);
    rdc(12'h0FC, 32'hA5A5_0000, 32'hA5A5_0000, "R6 write stored");
    @(negedge clk); irq_in = 2'b00;
    @(negedge clk);
    irq_in = 2'b10; v = 1; w = 1; a = 12'h0FC; d = 32'h0; s = 4'hF;
    @(posedge clk); #1 v = 0; w = 0;
    @(negedge clk);
    rdc(12'h0FC, 32'h2, 32'h0, "R6 event wins over write");
    @(negedge clk); irq_in = 2'b00;
    @(negedge clk); @(negedge clk);
    rdc(12'h0FC, 32'h0, 32'h0, "R6 fall clears");
    // R10 back-to-back reads
    @(negedge clk);
    v = 1; w = 0; a = 12'h004;
    @(negedge clk); a = 12'h018;
    @(negedge clk); v = 0;
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule